// File: doc/BRIEF.md
# Burst-Capable Line Read Slave

This block is a synchronous bus slave backed by a small internal array of 32-bit words. A master opens a cycle by pulsing a start strobe together with a word address, a two-bit size code and a read/write flag. The slave latches these, waits a programmable number of clocks, and then answers with an acknowledge pulse. Read data is presented in the same clock as the acknowledge.

A line read fetches a whole 16-byte line. When bursting is enabled at the start of the cycle, the slave returns four long words, one per acknowledge. The master keeps its address frozen, so the slave steps the low word-select bits itself, wrapping inside the line. The slave also drives the burst-inhibit flag low on every acknowledge of the burst. When bursting is disabled, the slave acknowledges only the first long word and raises burst-inhibit. The master then fetches the rest with single long-word cycles. Writes store one long word per cycle.

Top module: `burst_line_slave`

## Requirements
- R1: While reset is low and after its release, `ack_o`, `binh_o` and `rdata_o` are all zero.
- R2: `start_i` is taken only while the slave is idle. It latches address, size, direction, burst enable and wait count. The first acknowledge goes high exactly 1+W clocks after the latching edge, where W is `wait_i` as latched.
- R3: A read with size code 2'b11 (line) and burst enable high gives exactly four acknowledges. The words come from the captured line at word-select values s, s+1, s+2, s+3 modulo 4, where s is address bits 3:2. `binh_o` is low on all four.
- R4: Each later beat of a burst is acknowledged 1+W clocks after the previous acknowledge. `ack_o` stays high for one clock per beat.
- R5: A line read with burst enable low gives one acknowledge with the word at the captured address, and `binh_o` is high with it.
- R6: A read of size 2'b00 (long word), 2'b01 (byte) or 2'b10 (word) gives one acknowledge. It returns the whole long word that holds the address, with `binh_o` high.
- R7: A write (`rw_i` low, 1 means read) stores `wdata_i` as sampled with the start strobe into the addressed word. It gives one acknowledge with `binh_o` high.
- R8: While a cycle is in progress, any change on `start_i`, `addr_i`, `wait_i` and `burst_en_i` has no effect on that cycle's acknowledge timing, data or beat count.
- R9: `binh_o` is never high in a clock where `ack_o` is low.
- R10: After reset, word i of the array holds 32'hC0DE0000 + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start-of-cycle strobe |
| rw_i | input | 1 | 1 = read, 0 = write |
| size_i | input | 2 | 00 long, 01 byte, 10 word, 11 line |
| addr_i | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1:2) |
| wdata_i | input | 32 | Write data, sampled with start |
| burst_en_i | input | 1 | Serve line reads as bursts |
| wait_i | input | WAIT_W | Wait clocks inserted before each acknowledge |
| rdata_o | output | 32 | Read data, valid with acknowledge |
| ack_o | output | 1 | Transfer acknowledge, one clock per beat |
| binh_o | output | 1 | Burst inhibit, meaningful with acknowledge |

## Verification
The assertions assume that after reset the master raises `start_i` only to begin a new cycle. Within a burst, beat count and word select must advance once per acknowledge. The bench therefore drives every input half a clock away from the active edge and opens each cycle only after the previous one has fully drained. The only exception is a deliberate mid-cycle strobe, together with altered wait and burst-enable values, that probes the ignore rule. Wait counts stay small, so every acknowledge position can be predicted exactly as a multiple of 1+W.

// File: rtl/burst_line_slave.sv
module burst_line_slave #(
  parameter int MEM_WORDS = 64,
  parameter int WAIT_W    = 4,
  localparam int IDX_W    = $clog2(MEM_WORDS),
  localparam int ADDR_W   = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rw_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:2] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              burst_en_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic [31:0]       rdata_o,
  output logic              ack_o,
  output logic              binh_o
);

  localparam logic [1:0] SZ_LINE = 2'b11;

  logic [31:0]       mem [MEM_WORDS];
  logic              busy_q, rw_q, burst_q;
  logic [ADDR_W-1:2] addr_q;
  logic [WAIT_W-1:0] wcfg_q, wcnt_q;
  logic [1:0]        beat_q;
  logic [31:0]       wdat_q;

  logic [1:0]        col;
  logic [IDX_W-1:0]  idx;
  logic              last_beat;

  assign col       = addr_q[3:2] + beat_q;
  assign idx       = {addr_q[ADDR_W-1:4], col};
  assign last_beat = !burst_q || (beat_q == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rw_q    <= 1'b0;
      burst_q <= 1'b0;
      addr_q  <= '0;
      wcfg_q  <= '0;
      wcnt_q  <= '0;
      beat_q  <= '0;
      wdat_q  <= '0;
      ack_o   <= 1'b0;
      binh_o  <= 1'b0;
      rdata_o <= '0;
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= 32'hC0DE0000 + 32'(i);
    end else begin
      ack_o  <= 1'b0;
      binh_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          rw_q    <= rw_i;
          burst_q <= rw_i && (size_i == SZ_LINE) && burst_en_i;
          addr_q  <= addr_i;
          wcfg_q  <= wait_i;
          wcnt_q  <= wait_i;
          beat_q  <= '0;
          wdat_q  <= wdata_i;
        end
      end else if (wcnt_q != '0) begin
        wcnt_q <= wcnt_q - 1'b1;
      end else begin
        ack_o  <= 1'b1;
        binh_o <= !burst_q;
        if (rw_q) rdata_o  <= mem[idx];
        else      mem[idx] <= wdat_q;
        beat_q <= beat_q + 1'b1;
        wcnt_q <= wcfg_q;
        if (last_beat) busy_q <= 1'b0;
      end
    end
  end

endmodule

module burst_line_slave_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              ack_o,
  input logic              binh_o,
  input logic              busy_q,
  input logic [1:0]        beat_q,
  input logic [ADDR_W-1:2] addr_q
);

  // R9
  binh_only_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    binh_o |-> ack_o);

  // R8
  addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> $stable(addr_q));

  // R4
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (beat_q == 2'($past(beat_q) + 2'd1)));

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && beat_q == 2'd0));

  // R2
  idle_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> !ack_o);

endmodule

bind burst_line_slave burst_line_slave_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_burst_line_slave.sv
module sim_burst_line_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, rw_i = 1'b1, burst_en_i = 1'b0;
  logic [1:0]  size_i = 2'b00;
  logic [7:2]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  wait_i = '0;
  logic [31:0] rdata_o;
  logic        ack_o, binh_o;

  int checks = 0, errors = 0;
  logic [31:0] model [64];

  always #10 clk = ~clk;

  burst_line_slave u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rw_i(rw_i), .size_i(size_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .burst_en_i(burst_en_i), .wait_i(wait_i),
    .rdata_o(rdata_o), .ack_o(ack_o), .binh_o(binh_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run(input logic [7:0] a, input logic [1:0] sz, input bit rd,
                     input logic [31:0] wd, input bit ben, input int w,
                     input int nexp, input bit ebinh, input bit poke, input string tag);
    int b, ix;
    bit ea;
    addr_i = a[7:2]; size_i = sz; rw_i = rd; wdata_i = wd;
    burst_en_i = ben; wait_i = 4'(w); start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    for (int k = 1; k <= 4*(w+1)+3; k++) begin
      if (poke && k == 1) begin
        start_i = 1'b1; addr_i = ~a[7:2]; wait_i = '0; burst_en_i = ~ben; wdata_i = ~wd;
      end
      @(posedge clk); @(negedge clk);
      start_i = 1'b0;
      ea = (k % (w+1) == 0) && (k / (w+1) <= nexp);
      chk(ack_o === ea, {tag, " ack"}, {31'b0, ack_o}, {31'b0, ea});
      if (ea) begin
        b  = k / (w+1) - 1;
        ix = (int'(a[7:4]) * 4) + ((int'(a[3:2]) + b) % 4);
        if (rd) chk(rdata_o === model[ix], {tag, " data"}, rdata_o, model[ix]);
        else model[ix] = wd;
        chk(binh_o === ebinh, {tag, " binh"}, {31'b0, binh_o}, {31'b0, ebinh});
      end else begin
        chk(binh_o === 1'b0, "R9 binh idle", {31'b0, binh_o}, 32'd0);
      end
    end
  endtask

  task automatic t_reset;
    chk(ack_o === 1'b0, "R1 ack", {31'b0, ack_o}, 32'd0);
    chk(binh_o === 1'b0, "R1 binh", {31'b0, binh_o}, 32'd0);
    chk(rdata_o === 32'd0, "R1 rdata", rdata_o, 32'd0);
  endtask

  task automatic t_burst_aligned;  // R3 and R10: reset contents, start at word 0 of line
    run(8'h20, 2'b11, 1'b1, 32'd0, 1'b1, 0, 4, 1'b0, 1'b0, "R3/R10");
  endtask

  task automatic t_burst_wrap;     // R2 latency, R4 spacing, wrap from word 2
    run(8'h38, 2'b11, 1'b1, 32'd0, 1'b1, 2, 4, 1'b0, 1'b0, "R2/R4");
  endtask

  task automatic t_inhibit;
    run(8'h14, 2'b11, 1'b1, 32'd0, 1'b0, 1, 1, 1'b1, 1'b0, "R5");
  endtask

  task automatic t_single;
    run(8'h47, 2'b01, 1'b1, 32'd0, 1'b1, 1, 1, 1'b1, 1'b0, "R6 byte");
    run(8'h5C, 2'b00, 1'b1, 32'd0, 1'b1, 0, 1, 1'b1, 1'b0, "R6 long");
    run(8'h62, 2'b10, 1'b1, 32'd0, 1'b1, 3, 1, 1'b1, 1'b0, "R6 word");
  endtask

  task automatic t_write;
    run(8'h08, 2'b00, 1'b0, 32'h12345678, 1'b1, 1, 1, 1'b1, 1'b0, "R7 write");
    run(8'h0C, 2'b11, 1'b1, 32'd0, 1'b1, 0, 4, 1'b0, 1'b0, "R7 readback");
  endtask

  task automatic t_busy;
    run(8'h24, 2'b11, 1'b1, 32'd0, 1'b1, 3, 4, 1'b0, 1'b1, "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 32'hC0DE0000 + 32'(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    t_reset();
    t_burst_aligned();
    t_burst_wrap();
    t_inhibit();
    t_single();
    t_write();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule